// File: doc/BRIEF.md
# Parameter-Seeded Dual-Port RAM with Input-Side Registers

This block is a single-clock memory with one write port and one read port. Every input is captured in a register on the clock edge: the write enable, write address and write data on the write side, and the address on the read side. The read data is not registered. It is a combinational lookup into the storage array, indexed by the captured read address, so a read address presented before an edge produces its word shortly after that edge.

A write that has been captured commits to the array on the following edge. No forwarding path sits in front of the read data. When the captured read address matches the location committed on the same edge, the output shows the new word after that edge, simply because the lookup reads the updated array.

The power-up image of the array is computed at elaboration from two parameters, so no external content file is needed. Location i holds (INIT_BASE + i * INIT_STEP) truncated to the word width. The array itself has no reset. The active-low reset clears only the input registers.

Top module: `dpram_paraminit`

## Requirements
- R1: The array holds 2**ADDR_BITS words of DATA_BITS bits each, and every address from 0 up to the highest one (2**ADDR_BITS - 1) is usable.
- R2: The read address is captured on the rising edge. After that edge, rdData equals the array word at the captured address, with no further register on the output.
- R3: The write enable, write address and write data are captured on a rising edge. A captured write with the enable at 1 updates the addressed word on the next rising edge.
- R4: Before any write, word i reads as (INIT_BASE + i * INIT_STEP) mod 2**DATA_BITS.
- R5: While the captured write enable is 0, no word of the array changes, whatever the write address and write data inputs carry.
- R6: Suppose the captured read address equals the location that a write commits on the same edge. After that edge, rdData shows the newly written word.
- R7: With rstN at 0, the captured write enable and both captured addresses are 0, so rdData shows word 0. A write captured before reset is asserted is dropped, and all array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register and for the array write |
| rstN | input | 1 | Asynchronous active-low reset of the input registers only |
| wrEn | input | 1 | Write request, captured on the edge |
| wrAddr | input | ADDR_BITS | Write location, captured on the edge |
| wrData | input | DATA_BITS | Write word, captured on the edge |
| rdAddr | input | ADDR_BITS | Read location, captured on the edge |
| rdData | output | DATA_BITS | Word at the captured read address, combinational |

## Verification
The bench targets the read that lands on the same edge as a write to the same location, at every address. A design that had registered the output, or that read the array before the update, would return the old word there. Sweeps with the write enable low but with live address and data inputs would expose a design that writes without the enable. Full read sweeps, both from power-up and after writes, catch a wrong initial image, a wrong address width or a dropped top location. A reset asserted while a write is pending shows whether reset wrongly commits that write or wipes the stored contents.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Strobes passed from the control side to the storage datapath.
  typedef struct packed {
    logic commitWr;   // captured write request, commits on the coming edge
  } dpramStrobe_t;

  // Elaboration-time content generator: base plus index times step.
  function automatic logic [63:0] initWord(input longint unsigned base,
                                           input longint unsigned step,
                                           input longint unsigned idx);
    return 64'(base + idx * step);
  endfunction

endpackage

// File: rtl/dpram_ctrl.sv
module dpram_ctrl
  import dpram_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  output dpramStrobe_t strb
);

  logic wrEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrEnQ <= 1'b0;
    else       wrEnQ <= wrEn;
  end

  always_comb begin
    strb.commitWr = wrEnQ;
  end

  // R3: a write request becomes a commit strobe one edge later
  a_r3_req_captured: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> strb.commitWr);

  // R5: no request means no commit on the next edge
  a_r5_idle_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !strb.commitWr);

endmodule

// File: rtl/dpram_store.sv
module dpram_store
  import dpram_pkg::*;
#(
  parameter int          ADDR_BITS = 4,
  parameter int          DATA_BITS = 8,
  parameter longint unsigned INIT_BASE = 29,
  parameter longint unsigned INIT_STEP = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpramStrobe_t         strb,
  input  logic [ADDR_BITS-1:0] wrAddrIn,
  input  logic [DATA_BITS-1:0] wrDataIn,
  input  logic [ADDR_BITS-1:0] rdAddrIn,
  output logic [DATA_BITS-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_BITS;

  typedef logic [DATA_BITS-1:0] word_t;
  typedef word_t image_t [DEPTH];

  function automatic image_t buildImage();
    image_t img;
    for (int i = 0; i < DEPTH; i++) begin
      img[i] = word_t'(initWord(INIT_BASE, INIT_STEP, longint'(i)));
    end
    return img;
  endfunction

  image_t mem = buildImage();

  logic [ADDR_BITS-1:0] wrAddrQ;
  logic [DATA_BITS-1:0] wrDataQ;
  logic [ADDR_BITS-1:0] rdAddrQ;

  // Input-side registers; the array itself is never reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrQ <= '0;
      wrDataQ <= '0;
      rdAddrQ <= '0;
    end else begin
      wrAddrQ <= wrAddrIn;
      wrDataQ <= wrDataIn;
      rdAddrQ <= rdAddrIn;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commitWr) mem[wrAddrQ] <= wrDataQ;
  end

  // Unregistered read through the captured address, no bypass path.
  always_comb begin
    rdData = mem[rdAddrQ];
  end

  // R2: the read address is captured on each edge
  a_r2_rd_addr_captured: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> rdAddrQ == $past(rdAddrIn));

  // R6: a same-edge collision shows the freshly written word
  a_r6_collision_new_word: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWr && wrAddrQ == rdAddrIn) |=> rdData == $past(wrDataQ));

  // R5: no commit and an unchanged read address leave the output still
  a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commitWr && rdAddrIn == rdAddrQ) |=> $stable(rdData));

endmodule

// File: rtl/dpram_paraminit.sv
module dpram_paraminit
  import dpram_pkg::*;
#(
  parameter int          ADDR_BITS = 4,
  parameter int          DATA_BITS = 8,
  parameter longint unsigned INIT_BASE = 29,
  parameter longint unsigned INIT_STEP = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_BITS-1:0] wrAddr,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic [ADDR_BITS-1:0] rdAddr,
  output logic [DATA_BITS-1:0] rdData
);

  dpramStrobe_t strb;

  dpram_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .strb (strb)
  );

  dpram_store #(
    .ADDR_BITS (ADDR_BITS),
    .DATA_BITS (DATA_BITS),
    .INIT_BASE (INIT_BASE),
    .INIT_STEP (INIT_STEP)
  ) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrAddrIn (wrAddr),
    .wrDataIn (wrData),
    .rdAddrIn (rdAddr),
    .rdData   (rdData)
  );

  // R7: while reset is held the write side stays idle
  a_r7_reset_idle: assert property (@(posedge clk)
    !rstN |-> !strb.commitWr);

endmodule

// File: tb/dpram_paraminit_test.sv
module dpram_paraminit_test;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int BASE  = 29;
  localparam int STEP  = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dpram_paraminit #(
    .ADDR_BITS (AW),
    .DATA_BITS (DW),
    .INIT_BASE (BASE),
    .INIT_STEP (STEP)
  ) uut (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

  // Reference model built from the requirements.
  logic [DW-1:0] refMem [DEPTH];
  logic          mWe = 1'b0;
  logic [AW-1:0] mWa = '0;
  logic [DW-1:0] mWd = '0;
  logic [AW-1:0] mRa = '0;

  function automatic logic [DW-1:0] expectInit(int i);
    return DW'((BASE + i * STEP) % (1 << DW));
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = expectInit(i);
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWe <= 1'b0;
      mWa <= '0;
      mWd <= '0;
      mRa <= '0;
    end else begin
      if (mWe) refMem[mWa] <= mWd;
      mWe <= wrEn;
      mWa <= wrAddr;
      mWd <= wrData;
      mRa <= rdAddr;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: rdData actual=%h expected=%h (read addr %0d)",
               req, rdData, exp, mRa);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, compare at the next fall.
  task automatic step(input bit we, input int wa, input int wd, input int ra,
                      input string req);
    wrEn   = we;
    wrAddr = AW'(wa);
    wrData = DW'(wd);
    rdAddr = AW'(ra);
    @(posedge clk);
    @(negedge clk);
    check(req, refMem[mRa]);
  endtask

  task automatic finishUp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R7: reset state shows word 0 of the initial image
    check("R7", expectInit(0));
    rstN = 1'b1;
    @(negedge clk);

    // R4 and R2: full read sweep of the power-up image
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, 0, 0, a, "R4");
      checks++;
      if (rdData !== expectInit(a)) begin
        errors++;
        $display("FAIL R4: addr %0d actual=%h expected=%h", a, rdData, expectInit(a));
      end
    end

    // R3: write every location, then read them back
    for (int a = 0; a < DEPTH; a++) step(1'b1, a, (a * 7 + 3) ^ 8'h5A, 0, "R3");
    step(1'b0, 0, 0, 0, "R3");
    for (int a = 0; a < DEPTH; a++) step(1'b0, 0, 0, a, "R3");

    // R1: highest location is written and read back
    step(1'b1, DEPTH - 1, 8'hC3, 0, "R1");
    step(1'b0, 0, 0, DEPTH - 1, "R1");
    checks++;
    if (rdData !== 8'hC3) begin
      errors++;
      $display("FAIL R1: top addr actual=%h expected=%h", rdData, 8'hC3);
    end

    // R6: read lands on the same edge as the write commit, every address
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b1, a, 8'hA0 + a, (a + 5) % DEPTH, "R6");
      step(1'b0, 0, 0, a, "R6");
      checks++;
      if (rdData !== DW'(8'hA0 + a)) begin
        errors++;
        $display("FAIL R6: addr %0d actual=%h expected=%h", a, rdData, DW'(8'hA0 + a));
      end
    end

    // R2: back-to-back collisions with changing data on one address
    for (int k = 0; k < 6; k++) step(1'b1, 9, 8'h30 + k * 11, 9, "R2");

    // R5: write enable low with live address and data; then verify nothing moved
    for (int a = 0; a < DEPTH; a++) step(1'b0, a, 8'hFF - a, a, "R5");
    for (int a = 0; a < DEPTH; a++) step(1'b0, 0, 0, a, "R5");

    // R7: write captured, then reset before its commit edge drops it
    step(1'b1, 3, 8'h77, 4, "R7");
    rstN = 1'b0;
    #1;
    mWe = 1'b0;
    @(negedge clk);
    check("R7", refMem[0]);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 0, 0, 3, "R7");
    checks++;
    if (rdData === 8'h77) begin
      errors++;
      $display("FAIL R7: dropped write appeared actual=%h expected=%h", rdData, refMem[3]);
    end
    for (int a = 0; a < DEPTH; a++) step(1'b0, 0, 0, a, "R7");

    done = 1'b1;
    finishUp();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finishUp();
    end
  end

endmodule